// File: doc/BRIEF.md
# Hot-Plug Slot Control and Status Registers

This block keeps the slot control and slot status registers of a downstream port that supports hot-plug. Software reaches both registers through a plain write/read port with byte enables. The selected register is read back combinationally. The physical side of the slot reports four things to the block: a hot-add or a removal request, a cold-plug presence indication at boot, and attention button presses. The block records these as status events. It then decides whether an interrupt is pending and tells the host in one of two ways: a one-cycle message pulse that carries a 5-bit vector number, or a level interrupt line.

A write to the control register is treated as one command. The command completes at once, and the command-completed event is raised one cycle later. An electromechanical interlock is modelled by a status bit. A write-one strobe in the control register toggles that bit. While the interlock is engaged, hot-add and removal requests are refused with a busy strobe. Notification is driven by a two-state machine with the states `NT_QUIET` (no pending condition reported) and `NT_RAISED` (pending condition reported). There are two transitions. `QUIET->RAISED` is taken when the pending condition becomes true. `RAISED->QUIET` is taken when it becomes false. Each transition taken while message mode is on emits one message pulse.

Top module: `hpslot_ctrl`

## Requirements
- R1: Any write to the control register (`wr_sel`=0) with at least one byte enable set is one command. The command-completed status bit (status bit 2) reads 1 from the second clock edge after the write edge onward. A write with no byte enable set is not a command.
- R2: Writing 1 to control bit 8 (byte 1) toggles the interlock status (status bit 7). Control bit 8 always reads 0.
- R3: Status bits 0 (button pressed), 1 (presence changed) and 2 (command completed) are cleared by writing 1 to them with byte enable 0. Status bits 6 and 7 ignore writes. Unused bits in both registers read 0.
- R4: The pending condition is control bit 3 (hot-plug interrupt enable) ANDed with the OR of the three event bits, each masked by its own enable: control bit 0 for the button, bit 1 for presence changed, bit 2 for command completed.
- R5: A notification is issued only when the pending condition changes value. Raising an event bit that is already set gives no new message pulse.
- R6: When `msg_en` is 1, each change of the pending condition produces a one-cycle `msg_valid` pulse one edge after the change, with `msg_vec` equal to `msg_num`. When `msg_en` is 0, `intx` follows the reported pending state as a level.
- R7: An accepted hot-add sets presence state (status bit 6) and presence changed. An accepted removal clears presence state and sets presence changed. `hp_ack` pulses one cycle after every request.
- R8: `cold_present` sets presence state without raising any event bit.
- R9: A hot-plug request while the interlock status is 1 returns `hp_busy` together with `hp_ack`, and leaves presence state and presence changed as they were.
- R10: After reset, the control register reads 0x00F0: all enables are 0, and both indicator fields (attention bits 5:4, power bits 7:6) are 2'b11, meaning off. The status register reads 0x0000.
- R11: Control bits 7:0 are written only when byte enable 0 is set. Indicator fields take any 2-bit value that is written.
- R12: If an event is raised in the same cycle as a write-1-to-clear of its bit, the bit ends set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 control, 1 status |
| wr_be | input | 2 | Byte enables for the write |
| wr_data | input | 16 | Write data |
| rd_sel | input | 1 | Read target: 0 control, 1 status |
| rd_data | output | 16 | Read data of the selected register |
| btn_press | input | 1 | Attention button pressed (one-cycle) |
| cold_present | input | 1 | Device present at boot (one-cycle) |
| hp_req | input | 1 | Hot-plug request strobe |
| hp_add | input | 1 | Request kind: 1 add, 0 removal |
| hp_ack | output | 1 | Request acknowledge, one cycle |
| hp_busy | output | 1 | Request refused, interlock engaged |
| msg_en | input | 1 | Message interrupt mode enable |
| msg_num | input | 5 | Interrupt message number |
| msg_valid | output | 1 | Message interrupt pulse |
| msg_vec | output | 5 | Message number carried by the pulse |
| intx | output | 1 | Level interrupt line |

## Verification
The bench drives several cases where a wrong design would fail in a visible way. A second button press while the button bit is still set must produce no pulse; a design that notifies on every event would emit a duplicate message. Clearing the last enabled event must send a pulse on the falling edge of the pending condition too; a design that only notifies on the rising edge would leave the host's view stale. A removal request while the interlock is engaged must leave presence untouched; a design that ignores the lock would drop presence or raise presence changed. A write with no byte enables, and a write to byte 1 only, show whether the command-completed timing and the byte gating are right. A press that lands in the same cycle as its own clear checks that the set takes priority.

// File: rtl/hpslot_pkg.sv
package hpslot_pkg;
    // control register field positions
    localparam int CTL_EN_BTN   = 0;
    localparam int CTL_EN_PDC   = 1;
    localparam int CTL_EN_CC    = 2;
    localparam int CTL_HPIE     = 3;
    localparam int CTL_ATTN_LSB = 4;
    localparam int CTL_PWR_LSB  = 6;
    localparam int CTL_LOCK_STB = 8;
    // status register field positions
    localparam int ST_BTN  = 0;
    localparam int ST_PDC  = 1;
    localparam int ST_CC   = 2;
    localparam int ST_PDS  = 6;
    localparam int ST_LOCK = 7;
    // indicator encoding
    localparam int          IND_W   = 2;
    localparam logic [1:0]  IND_OFF = 2'b11;

    typedef enum logic {
        NT_QUIET  = 1'b0,
        NT_RAISED = 1'b1
    } notify_state_t;
endpackage

// File: rtl/hpslot_ctl_reg.sv
module hpslot_ctl_reg
    import hpslot_pkg::*;
#(
    parameter int REG_W = 16,
    localparam int NB   = REG_W / 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_ctl,
    input  logic [NB-1:0]    wr_be,
    input  logic [REG_W-1:0] wr_data,
    output logic [REG_W-1:0] ctl_img,
    output logic             en_btn,
    output logic             en_pdc,
    output logic             en_cc,
    output logic             hpie,
    output logic             lock_toggle,
    output logic             cmd_done
);
    logic [IND_W-1:0] attn_ind;
    logic [IND_W-1:0] pwr_ind;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_btn   <= 1'b0;
            en_pdc   <= 1'b0;
            en_cc    <= 1'b0;
            hpie     <= 1'b0;
            attn_ind <= IND_OFF;
            pwr_ind  <= IND_OFF;
            cmd_done <= 1'b0;
        end else begin
            if (wr_ctl && wr_be[0]) begin
                en_btn   <= wr_data[CTL_EN_BTN];
                en_pdc   <= wr_data[CTL_EN_PDC];
                en_cc    <= wr_data[CTL_EN_CC];
                hpie     <= wr_data[CTL_HPIE];
                attn_ind <= wr_data[CTL_ATTN_LSB +: IND_W];
                pwr_ind  <= wr_data[CTL_PWR_LSB +: IND_W];
            end
            cmd_done <= wr_ctl && (|wr_be);
        end
    end

    // strobe bit: acts on the write, never stored
    assign lock_toggle = wr_ctl && wr_be[CTL_LOCK_STB / 8] && wr_data[CTL_LOCK_STB];

    always_comb begin
        ctl_img = '0;
        ctl_img[CTL_EN_BTN] = en_btn;
        ctl_img[CTL_EN_PDC] = en_pdc;
        ctl_img[CTL_EN_CC]  = en_cc;
        ctl_img[CTL_HPIE]   = hpie;
        ctl_img[CTL_ATTN_LSB +: IND_W] = attn_ind;
        ctl_img[CTL_PWR_LSB +: IND_W]  = pwr_ind;
    end
endmodule

// File: rtl/hpslot_stat_reg.sv
module hpslot_stat_reg
    import hpslot_pkg::*;
#(
    parameter int REG_W = 16,
    localparam int NB   = REG_W / 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_stat,
    input  logic [NB-1:0]    wr_be,
    input  logic [REG_W-1:0] wr_data,
    input  logic             cmd_done,
    input  logic             lock_toggle,
    input  logic             btn_press,
    input  logic             cold_present,
    input  logic             hp_req,
    input  logic             hp_add,
    output logic             ev_btn,
    output logic             ev_pdc,
    output logic             ev_cc,
    output logic             pds,
    output logic             ils,
    output logic             hp_ack,
    output logic             hp_busy,
    output logic [REG_W-1:0] stat_img
);
    logic clr_lo;
    logic hp_ok;

    assign clr_lo = wr_stat && wr_be[0];
    assign hp_ok  = hp_req && !ils;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ev_btn  <= 1'b0;
            ev_pdc  <= 1'b0;
            ev_cc   <= 1'b0;
            pds     <= 1'b0;
            ils     <= 1'b0;
            hp_ack  <= 1'b0;
            hp_busy <= 1'b0;
        end else begin
            // a new event wins over a same-cycle clear
            ev_btn <= btn_press || (ev_btn && !(clr_lo && wr_data[ST_BTN]));
            ev_pdc <= hp_ok     || (ev_pdc && !(clr_lo && wr_data[ST_PDC]));
            ev_cc  <= cmd_done  || (ev_cc  && !(clr_lo && wr_data[ST_CC]));
            if (hp_ok)
                pds <= hp_add;
            else if (cold_present)
                pds <= 1'b1;
            ils     <= ils ^ lock_toggle;
            hp_ack  <= hp_req;
            hp_busy <= hp_req && ils;
        end
    end

    always_comb begin
        stat_img = '0;
        stat_img[ST_BTN]  = ev_btn;
        stat_img[ST_PDC]  = ev_pdc;
        stat_img[ST_CC]   = ev_cc;
        stat_img[ST_PDS]  = pds;
        stat_img[ST_LOCK] = ils;
    end

    AST_LOCK_TOGGLES: assert property (@(posedge clk) disable iff (!rst_n) lock_toggle |=> (ils != $past(ils))); // R2
    AST_CC_W1C: assert property (@(posedge clk) disable iff (!rst_n) (clr_lo && wr_data[ST_CC] && !cmd_done) |=> !ev_cc); // R3
    AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n) (hp_req && ils && !cold_present) |=> (hp_busy && hp_ack && $stable(pds))); // R9
endmodule

// File: rtl/hpslot_notify.sv
module hpslot_notify
    import hpslot_pkg::*;
#(
    parameter int VEC_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pend,
    input  logic             msg_en,
    input  logic [VEC_W-1:0] msg_num,
    output logic             msg_valid,
    output logic [VEC_W-1:0] msg_vec,
    output logic             intx
);
    notify_state_t state, state_nx;
    logic          change;

    always_comb begin
        state_nx = state;
        change   = 1'b0;
        unique case (state)
            NT_QUIET:  if (pend)  begin state_nx = NT_RAISED; change = 1'b1; end
            NT_RAISED: if (!pend) begin state_nx = NT_QUIET;  change = 1'b1; end
            default:   state_nx = NT_QUIET;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= NT_QUIET;
        else        state <= state_nx;
    end

    // outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            msg_valid <= 1'b0;
            msg_vec   <= '0;
        end else begin
            msg_valid <= msg_en && change;
            msg_vec   <= msg_num;
        end
    end

    assign intx = (state == NT_RAISED) && !msg_en;

    AST_QUIET_SILENT: assert property (@(posedge clk) disable iff (!rst_n) (state == NT_QUIET && !pend) |=> !msg_valid); // R5
    AST_MSG_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n) msg_valid |-> $past(msg_en)); // R6
endmodule

// File: rtl/hpslot_ctrl.sv
module hpslot_ctrl
    import hpslot_pkg::*;
#(
    parameter int REG_W = 16,
    parameter int VEC_W = 5,
    localparam int NB   = REG_W / 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             wr_sel,
    input  logic [NB-1:0]    wr_be,
    input  logic [REG_W-1:0] wr_data,
    input  logic             rd_sel,
    output logic [REG_W-1:0] rd_data,
    input  logic             btn_press,
    input  logic             cold_present,
    input  logic             hp_req,
    input  logic             hp_add,
    output logic             hp_ack,
    output logic             hp_busy,
    input  logic             msg_en,
    input  logic [VEC_W-1:0] msg_num,
    output logic             msg_valid,
    output logic [VEC_W-1:0] msg_vec,
    output logic             intx
);
    logic [REG_W-1:0] ctl_img, stat_img;
    logic en_btn, en_pdc, en_cc, hpie, lock_toggle, cmd_done;
    logic ev_btn, ev_pdc, ev_cc, pds, ils;
    logic pend;

    hpslot_ctl_reg #(.REG_W(REG_W)) u_ctl (
        .clk(clk), .rst_n(rst_n), .wr_ctl(wr_en && !wr_sel), .wr_be(wr_be),
        .wr_data(wr_data), .ctl_img(ctl_img), .en_btn(en_btn), .en_pdc(en_pdc),
        .en_cc(en_cc), .hpie(hpie), .lock_toggle(lock_toggle), .cmd_done(cmd_done)
    );

    hpslot_stat_reg #(.REG_W(REG_W)) u_stat (
        .clk(clk), .rst_n(rst_n), .wr_stat(wr_en && wr_sel), .wr_be(wr_be),
        .wr_data(wr_data), .cmd_done(cmd_done), .lock_toggle(lock_toggle),
        .btn_press(btn_press), .cold_present(cold_present), .hp_req(hp_req),
        .hp_add(hp_add), .ev_btn(ev_btn), .ev_pdc(ev_pdc), .ev_cc(ev_cc),
        .pds(pds), .ils(ils), .hp_ack(hp_ack), .hp_busy(hp_busy), .stat_img(stat_img)
    );

    assign pend = hpie && ((ev_btn && en_btn) || (ev_pdc && en_pdc) || (ev_cc && en_cc));

    hpslot_notify #(.VEC_W(VEC_W)) u_ntf (
        .clk(clk), .rst_n(rst_n), .pend(pend), .msg_en(msg_en), .msg_num(msg_num),
        .msg_valid(msg_valid), .msg_vec(msg_vec), .intx(intx)
    );

    assign rd_data = rd_sel ? stat_img : ctl_img;

    AST_CMD_COMPLETES: assert property (@(posedge clk) disable iff (!rst_n) (wr_en && !wr_sel && (|wr_be)) |=> ##1 ev_cc); // R1
endmodule

// File: tb/sim_hpslot_ctrl.sv
module sim_hpslot_ctrl;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_en = 0, wr_sel = 0, rd_sel = 0;
    logic [1:0] wr_be = 0;
    logic [15:0] wr_data = 0;
    logic [15:0] rd_data;
    logic btn_press = 0, cold_present = 0, hp_req = 0, hp_add = 0;
    logic hp_ack, hp_busy, msg_valid, intx;
    logic msg_en = 0;
    logic [4:0] msg_num = 0, msg_vec;

    int checks = 0, errors = 0, cyc = 0;
    string phase = "R10";
    bit chk_on = 0;

    always #5 clk = ~clk;

    hpslot_ctrl u0 (.*);

    // reference model state
    bit m_eb, m_ep, m_ec, m_ie, m_btn, m_pdc, m_cc, m_pds, m_ils, m_cmd, m_ntf;
    bit m_ack, m_busy, m_mv;
    int m_attn, m_pwr, m_vec;

    always @(posedge clk) begin
        cyc++;
        if (!rst_n) begin
            {m_eb, m_ep, m_ec, m_ie, m_btn, m_pdc, m_cc, m_pds, m_ils, m_cmd, m_ntf} = '0;
            {m_ack, m_busy, m_mv} = '0;
            m_attn = 3; m_pwr = 3; m_vec = 0;
        end else begin
            bit pend_o, ils_o, cmd_o;
            pend_o = m_ie && ((m_btn && m_eb) || (m_pdc && m_ep) || (m_cc && m_ec));
            ils_o = m_ils; cmd_o = m_cmd;
            m_mv = msg_en && (pend_o != m_ntf);
            m_vec = msg_num;
            m_ntf = pend_o;
            m_cmd = wr_en && !wr_sel && (wr_be != 0);
            if (wr_en && !wr_sel && wr_be[0]) begin
                m_eb = wr_data[0]; m_ep = wr_data[1]; m_ec = wr_data[2]; m_ie = wr_data[3];
                m_attn = wr_data[5:4]; m_pwr = wr_data[7:6];
            end
            if (wr_en && !wr_sel && wr_be[1] && wr_data[8]) m_ils = !m_ils;
            if (wr_en && wr_sel && wr_be[0]) begin
                if (wr_data[0]) m_btn = 0;
                if (wr_data[1]) m_pdc = 0;
                if (wr_data[2]) m_cc = 0;
            end
            if (cmd_o) m_cc = 1;
            if (btn_press) m_btn = 1;
            if (cold_present) m_pds = 1;
            if (hp_req && !ils_o) begin m_pds = hp_add; m_pdc = 1; end
            m_ack = hp_req;
            m_busy = hp_req && ils_o;
        end
    end

    task automatic chk(input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h at cycle %0d", phase, what, act, exp, cyc);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && chk_on) begin
            int img;
            if (rd_sel)
                img = (int'(m_ils) << 7) | (int'(m_pds) << 6) | (int'(m_cc) << 2) | (int'(m_pdc) << 1) | int'(m_btn);
            else
                img = (m_pwr << 6) | (m_attn << 4) | (int'(m_ie) << 3) | (int'(m_ec) << 2) | (int'(m_ep) << 1) | int'(m_eb);
            chk("rd_data", rd_data, img);
            chk("intx", intx, m_ntf && !msg_en);
            chk("msg_valid", msg_valid, m_mv);
            if (m_mv) chk("msg_vec", msg_vec, m_vec);
            chk("hp_ack", hp_ack, m_ack);
            chk("hp_busy", hp_busy, m_busy);
        end
    end

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #2;
            rd_sel = !rd_sel;
        end
    endtask

    task automatic wr(input bit sel, input logic [1:0] be, input logic [15:0] d);
        @(posedge clk); #2;
        wr_en = 1; wr_sel = sel; wr_be = be; wr_data = d;
        @(posedge clk); #2;
        wr_en = 0; wr_be = 0;
        idle(3);
    endtask

    task automatic press();
        @(posedge clk); #2; btn_press = 1;
        @(posedge clk); #2; btn_press = 0;
        idle(3);
    endtask

    task automatic hotplug(input bit add);
        @(posedge clk); #2; hp_req = 1; hp_add = add;
        @(posedge clk); #2; hp_req = 0;
        idle(3);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #2 rst_n = 1; chk_on = 1;
        // R10 reset values seen on both registers
        phase = "R10"; idle(4);
        // R11 byte gating and indicator values; R1 command timing
        phase = "R11"; wr(0, 2'b01, 16'h0025);
        phase = "R1";  wr(0, 2'b00, 16'h00FF);
        phase = "R11"; wr(0, 2'b10, 16'h00FF);
        phase = "R1";  wr(0, 2'b11, 16'h0090);
        // R3 W1C and read-only status bits
        phase = "R3"; wr(1, 2'b11, 16'hFFFF);
        // R2 interlock strobe
        phase = "R2"; wr(0, 2'b10, 16'h0100); wr(0, 2'b10, 16'h0100); wr(0, 2'b10, 16'h0100);
        // R9 request refused under interlock
        phase = "R9"; hotplug(1); hotplug(0);
        phase = "R2"; wr(0, 2'b10, 16'h0100);
        phase = "R3"; wr(1, 2'b01, 16'h0007);
        // R4/R5/R6 level mode
        phase = "R4"; wr(0, 2'b01, 16'h0009); wr(1, 2'b01, 16'h0004);
        press();
        phase = "R5"; press();
        phase = "R6"; wr(1, 2'b01, 16'h0001);
        // message mode
        @(posedge clk); #2 msg_en = 1; msg_num = 5'd17; idle(2);
        press();
        phase = "R5"; press(); press();
        phase = "R6"; msg_num = 5'd31; wr(1, 2'b01, 16'h0001);
        phase = "R4"; wr(0, 2'b01, 16'h000C); wr(0, 2'b01, 16'h0004);
        wr(1, 2'b01, 16'h0004);
        // R7 hot add and removal with presence-change enable
        phase = "R7"; wr(0, 2'b01, 16'h000A);
        hotplug(1); wr(1, 2'b01, 16'h0002);
        hotplug(0);
        @(posedge clk); #2 msg_en = 0; idle(2);
        wr(1, 2'b01, 16'h0002);
        // R8 cold presence
        phase = "R8";
        @(posedge clk); #2 cold_present = 1;
        @(posedge clk); #2 cold_present = 0; idle(3);
        // R12 event and clear together
        phase = "R12"; wr(0, 2'b01, 16'h0009);
        @(posedge clk); #2 btn_press = 1; wr_en = 1; wr_sel = 1; wr_be = 2'b01; wr_data = 16'h0001;
        @(posedge clk); #2 btn_press = 0; wr_en = 0; wr_be = 0;
        idle(4);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #1000000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule